// File: doc/BRIEF.md
# Banked Scratchpad with Bank-Conflict Serialization

This block is a small on-chip scratchpad that a group of eight SIMD lanes shares. All lanes present their requests together as one group: each lane may be enabled or idle, may read or write, and carries its own 32-bit word address and write data. The storage is split into sixteen independent single-ported banks of 256 words each, which is 16 KB in all. Consecutive words fall in consecutive banks, so unit-stride lane patterns never collide.

Once a group has been accepted, the block finds which lanes aim at the same bank. It serves one lane per bank per cycle, always picking the lowest-numbered lane still waiting. Lanes on distinct banks finish in the same cycle. The group therefore takes as many service cycles as the most crowded bank needs, and never fewer than one. When every lane has been served, `done` pulses for one cycle and the read results appear on `lane_rdata`.

Groups enter through a valid/ready handshake. `grp_ready` is high only while the block is idle, and a group is taken on a clock edge where `grp_valid` and `grp_ready` are both high. The producer must hold the group steady until that edge. The result side has no back-pressure: results are valid in the cycle `done` is high and stay unchanged until the next group is accepted.

Top module: `banked_scratchpad`

## Requirements
- R1: Word address bits [3:0] select one of 16 banks and bits [11:4] select one of 256 rows in that bank. A word written at an address is returned by a later read of that same address.
- R2: A group is accepted on a rising edge where `grp_valid` and `grp_ready` are both high. From the next cycle on, `busy` is high and `grp_ready` is low until the cycle in which `done` is high.
- R3: Let N be the largest number of enabled lanes that address any single bank, with N taken as 1 for an empty group. `done` is high for exactly one cycle, in the cycle that follows the (N+1)-th rising edge after the accepting edge.
- R4: A group whose enabled lanes all address distinct banks completes with N = 1, so `done` follows the second edge after acceptance.
- R5: Lanes that share a bank are served in ascending lane-index order. A write from a lower lane is seen by a read of the same address from a higher lane in the same group. A read from a lower lane returns the value held before a higher lane's write in that group.
- R6: When several lanes of one group write the same address, the value from the highest-numbered of them remains stored.
- R7: In the `done` cycle, lane slot i of `lane_rdata` (bits 32*i+31 down to 32*i) holds the word read by lane i if lane i was an enabled read. It holds zero for an idle lane or a write lane. The bus is unchanged from then until the next acceptance.
- R8: After reset, `busy` and `done` are low, `grp_ready` is high, and `lane_rdata` is zero.
- R9: A lane whose enable bit is low changes no stored word, whatever its write flag, address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid | input | 1 | A request group is presented |
| grp_ready | output | 1 | The block can take a group (idle) |
| lane_en | input | 8 | Per-lane request enable, bit i for lane i |
| lane_we | input | 8 | Per-lane write flag (1 write, 0 read) |
| lane_addr | input | 96 | Per-lane 12-bit word address, lane i at bits 12*i+11 down to 12*i |
| lane_wdata | input | 256 | Per-lane write word, lane i at bits 32*i+31 down to 32*i |
| busy | output | 1 | A group is being serviced |
| done | output | 1 | One-cycle pulse when the group has completed |
| lane_rdata | output | 256 | Per-lane read result, lane i at bits 32*i+31 down to 32*i |

## Verification
The bench first fills the whole store with unit-stride groups, where every lane lands on a different bank. These groups separate a correct bank/row split from a wrong one, because a bad split shows up both in the cycle count and in the data read back. Directed groups then cover the extremes of the schedule and the ordering rules. They include eight lanes on one bank, which is the longest case, an empty group, and a mixed pattern where two lanes share a bank that is 16 words apart. They also put a read and a write to one address in the same group, or two writes to one address, so that an ascending service order can be told from any other. A disabled lane that carries a write is followed by a read of its address. Constrained-random groups squeezed into a 64-word window then produce many partial conflicts and duplicate addresses, each checked for latency and for per-lane data against a sequential model that walks the lanes in ascending order.

// File: rtl/sp_pkg.sv
package sp_pkg;

  // Group sequencer states
  typedef enum logic [1:0] {
    SP_IDLE  = 2'd0,
    SP_SERVE = 2'd1,
    SP_DRAIN = 2'd2
  } sp_state_e;

endpackage

// File: rtl/sp_bank.sv
// One single-ported storage bank: a single access per cycle, synchronous read.
module sp_bank #(
  parameter int ROW_BITS = 8,
  parameter int DW       = 32
) (
  input  logic                clk,
  input  logic                en,
  input  logic                we,
  input  logic [ROW_BITS-1:0] row,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata
);
  localparam int ROWS = 1 << ROW_BITS;

  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      else    rdata    <= mem[row];
    end
  end
endmodule

// File: rtl/sp_bank_arbiter.sv
// For every bank, selects the lowest-indexed pending lane that targets it.
module sp_bank_arbiter #(
  parameter int LANES     = 8,
  parameter int BANK_BITS = 4,
  parameter int LW        = 3
) (
  input  logic [LANES-1:0]                pending,
  input  logic [LANES-1:0][BANK_BITS-1:0] lane_bank,
  output logic [(1<<BANK_BITS)-1:0]       bank_act,
  output logic [(1<<BANK_BITS)-1:0][LW-1:0] bank_lane,
  output logic [(1<<BANK_BITS)*LANES-1:0] bank_gnt,
  output logic [LANES-1:0]                lane_grant
);
  localparam int BANKS = 1 << BANK_BITS;

  genvar b;
  generate
    for (b = 0; b < BANKS; b++) begin : g_bank
      logic [LANES-1:0] hit;
      logic [LANES-1:0] pick;

      always_comb begin
        for (int l = 0; l < LANES; l++) begin
          hit[l] = pending[l] && (lane_bank[l] == BANK_BITS'(b));
        end
      end

      // Lowest set bit of hit wins; scanning downward leaves the lowest.
      always_comb begin
        bank_act[b]  = 1'b0;
        bank_lane[b] = '0;
        pick         = '0;
        for (int l = LANES - 1; l >= 0; l--) begin
          if (hit[l]) begin
            bank_act[b]  = 1'b1;
            bank_lane[b] = l[LW-1:0];
            pick         = '0;
            pick[l]      = 1'b1;
          end
        end
      end

      assign bank_gnt[b*LANES +: LANES] = pick;
    end
  endgenerate

  always_comb begin
    lane_grant = '0;
    for (int k = 0; k < BANKS; k++) begin
      lane_grant = lane_grant | bank_gnt[k*LANES +: LANES];
    end
  end
endmodule

// File: rtl/sp_bank_xbar.sv
// Routes the chosen lane's row, write flag and data to each bank port.
module sp_bank_xbar #(
  parameter int LANES     = 8,
  parameter int BANK_BITS = 4,
  parameter int ROW_BITS  = 8,
  parameter int DW        = 32,
  parameter int LW        = 3
) (
  input  logic [(1<<BANK_BITS)-1:0]                   bank_act,
  input  logic [(1<<BANK_BITS)-1:0][LW-1:0]           bank_lane,
  input  logic [LANES-1:0][BANK_BITS+ROW_BITS-1:0]    q_addr,
  input  logic [LANES-1:0]                            q_we,
  input  logic [LANES-1:0][DW-1:0]                    q_wdata,
  output logic [(1<<BANK_BITS)-1:0]                   b_en,
  output logic [(1<<BANK_BITS)-1:0]                   b_we,
  output logic [(1<<BANK_BITS)-1:0][ROW_BITS-1:0]     b_row,
  output logic [(1<<BANK_BITS)-1:0][DW-1:0]           b_wdata
);
  localparam int BANKS = 1 << BANK_BITS;
  localparam int AW    = BANK_BITS + ROW_BITS;

  genvar b;
  generate
    for (b = 0; b < BANKS; b++) begin : g_port
      logic [AW-1:0] sel_addr;
      assign sel_addr   = q_addr[bank_lane[b]];
      assign b_en[b]    = bank_act[b];
      assign b_we[b]    = bank_act[b] && q_we[bank_lane[b]];
      assign b_row[b]   = sel_addr[AW-1:BANK_BITS];
      assign b_wdata[b] = q_wdata[bank_lane[b]];
    end
  endgenerate
endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad
  import sp_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int BANK_BITS = 4,
  parameter int ROW_BITS  = 8,
  parameter int DW        = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             grp_valid,
  output logic                             grp_ready,
  input  logic [LANES-1:0]                 lane_en,
  input  logic [LANES-1:0]                 lane_we,
  input  logic [LANES*(BANK_BITS+ROW_BITS)-1:0] lane_addr,
  input  logic [LANES*DW-1:0]              lane_wdata,
  output logic                             busy,
  output logic                             done,
  output logic [LANES*DW-1:0]              lane_rdata
);
  localparam int BANKS = 1 << BANK_BITS;
  localparam int AW    = BANK_BITS + ROW_BITS;
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;

  sp_state_e state;

  logic [LANES-1:0]                q_we;
  logic [LANES-1:0]                pending;
  logic [LANES-1:0]                rd_cap;
  logic [LANES-1:0]                lane_grant;
  logic [LANES-1:0]                pending_nxt;
  logic [LANES-1:0][AW-1:0]        in_addr;
  logic [LANES-1:0][DW-1:0]        in_wdata;
  logic [LANES-1:0][AW-1:0]        q_addr;
  logic [LANES-1:0][DW-1:0]        q_wdata;
  logic [LANES-1:0][DW-1:0]        res;
  logic [LANES-1:0][BANK_BITS-1:0] lane_bank;

  logic [BANKS-1:0]                bank_act;
  logic [BANKS-1:0][LW-1:0]        bank_lane;
  logic [BANKS*LANES-1:0]          bank_gnt;
  logic [BANKS-1:0]                b_en;
  logic [BANKS-1:0]                b_we;
  logic [BANKS-1:0][ROW_BITS-1:0]  b_row;
  logic [BANKS-1:0][DW-1:0]        b_wdata;
  logic [BANKS-1:0][DW-1:0]        b_rdata;

  logic accept;

  assign in_addr    = lane_addr;
  assign in_wdata   = lane_wdata;
  assign grp_ready  = (state == SP_IDLE);
  assign busy       = (state != SP_IDLE);
  assign accept     = grp_valid && grp_ready;
  assign lane_rdata = res;

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane_bank
      assign lane_bank[l] = q_addr[l][BANK_BITS-1:0];
    end
  endgenerate

  // ---------------- conflict resolution ----------------
  sp_bank_arbiter #(
    .LANES(LANES), .BANK_BITS(BANK_BITS), .LW(LW)
  ) u_arb (
    .pending   (pending),
    .lane_bank (lane_bank),
    .bank_act  (bank_act),
    .bank_lane (bank_lane),
    .bank_gnt  (bank_gnt),
    .lane_grant(lane_grant)
  );

  sp_bank_xbar #(
    .LANES(LANES), .BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS), .DW(DW), .LW(LW)
  ) u_xbar (
    .bank_act (bank_act),
    .bank_lane(bank_lane),
    .q_addr   (q_addr),
    .q_we     (q_we),
    .q_wdata  (q_wdata),
    .b_en     (b_en),
    .b_we     (b_we),
    .b_row    (b_row),
    .b_wdata  (b_wdata)
  );

  // ---------------- storage banks ----------------
  genvar b;
  generate
    for (b = 0; b < BANKS; b++) begin : g_bank
      sp_bank #(.ROW_BITS(ROW_BITS), .DW(DW)) u_bank (
        .clk  (clk),
        .en   (b_en[b]),
        .we   (b_we[b]),
        .row  (b_row[b]),
        .wdata(b_wdata[b]),
        .rdata(b_rdata[b])
      );
    end
  endgenerate

  // ---------------- group sequencer ----------------
  assign pending_nxt = pending & ~lane_grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SP_IDLE;
      pending <= '0;
      q_we    <= '0;
      q_addr  <= '0;
      q_wdata <= '0;
      rd_cap  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SP_IDLE: begin
          rd_cap <= '0;
          if (accept) begin
            pending <= lane_en;
            q_we    <= lane_we;
            q_addr  <= in_addr;
            q_wdata <= in_wdata;
            state   <= SP_SERVE;
          end
        end
        SP_SERVE: begin
          pending <= pending_nxt;
          rd_cap  <= lane_grant & ~q_we;
          if (pending_nxt == '0) state <= SP_DRAIN;
        end
        SP_DRAIN: begin
          rd_cap <= '0;
          done   <= 1'b1;
          state  <= SP_IDLE;
        end
        default: state <= SP_IDLE;
      endcase
    end
  end

  // Read results land one cycle after the bank access that produced them.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0;
    end else if (accept) begin
      res <= '0;
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (rd_cap[k]) res[k] <= b_rdata[lane_bank[k]];
      end
    end
  end

endmodule

// File: rtl/sp_chk.sv
module sp_chk #(
  parameter int LANES = 8,
  parameter int BANKS = 16,
  parameter int DW    = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   grp_valid,
  input logic                   grp_ready,
  input logic                   busy,
  input logic                   done,
  input logic [LANES*DW-1:0]    lane_rdata,
  input logic [BANKS*LANES-1:0] bank_gnt
);
  localparam int CW = $clog2(LANES + 3) + 1;

  logic [CW-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  // R2
  accept_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && grp_ready) |=> (busy && !grp_ready));

  // R2
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && grp_ready));

  // R3
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  service_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= CW'(LANES + 1));

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(grp_valid && grp_ready)) |=> $stable(lane_rdata));

  genvar b;
  generate
    for (b = 0; b < BANKS; b++) begin : g_port
      // R5
      one_access_per_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_gnt[b*LANES +: LANES]));
    end
  endgenerate
endmodule

bind banked_scratchpad sp_chk #(
  .LANES(LANES), .BANKS(1 << BANK_BITS), .DW(DW)
) u_sp_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .grp_valid (grp_valid),
  .grp_ready (grp_ready),
  .busy      (busy),
  .done      (done),
  .lane_rdata(lane_rdata),
  .bank_gnt  (bank_gnt)
);

// File: tb/test_banked_scratchpad.sv
`timescale 1ns/1ps
module test_banked_scratchpad;
  localparam int LANES  = 8;
  localparam int AW     = 12;
  localparam int DW     = 32;
  localparam int NWORDS = 1 << AW;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                grp_valid = 1'b0;
  logic                grp_ready;
  logic [LANES-1:0]    lane_en = '0;
  logic [LANES-1:0]    lane_we = '0;
  logic [LANES*AW-1:0] lane_addr = '0;
  logic [LANES*DW-1:0] lane_wdata = '0;
  logic                busy;
  logic                done;
  logic [LANES*DW-1:0] lane_rdata;

  always #2 clk = ~clk;

  banked_scratchpad i_banked_scratchpad (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_ready(grp_ready),
    .lane_en(lane_en), .lane_we(lane_we), .lane_addr(lane_addr),
    .lane_wdata(lane_wdata), .busy(busy), .done(done), .lane_rdata(lane_rdata)
  );

  logic [DW-1:0]    model [NWORDS];
  logic [AW-1:0]    g_addr [LANES];
  logic [DW-1:0]    g_wd   [LANES];
  logic [LANES-1:0] g_en, g_we;
  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mix(input int a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  // Expected cycles: worst per-bank lane count, at least one (R3).
  function automatic int worst_bank();
    int cnt [16];
    int w = 1;
    for (int k = 0; k < 16; k++) cnt[k] = 0;
    for (int l = 0; l < LANES; l++)
      if (g_en[l]) cnt[g_addr[l][3:0]]++;
    for (int k = 0; k < 16; k++) if (cnt[k] > w) w = cnt[k];
    return w;
  endfunction

  task automatic run_group(input string req);
    logic [DW-1:0] exp_rd [LANES];
    int n;
    int k;
    n = worst_bank();
    // Sequential model in ascending lane order (R5, R6, R9)
    for (int l = 0; l < LANES; l++) begin
      exp_rd[l] = '0;
      if (g_en[l]) begin
        if (g_we[l]) model[g_addr[l]] = g_wd[l];
        else         exp_rd[l] = model[g_addr[l]];
      end
    end
    @(negedge clk);
    check(grp_ready === 1'b1, "R2", "ready before group", {31'd0, grp_ready}, 32'd1);
    grp_valid = 1'b1;
    lane_en   = g_en;
    lane_we   = g_we;
    for (int l = 0; l < LANES; l++) begin
      lane_addr[l*AW +: AW]  = g_addr[l];
      lane_wdata[l*DW +: DW] = g_wd[l];
    end
    @(posedge clk);
    @(negedge clk);
    grp_valid = 1'b0;
    lane_en   = $urandom;
    lane_we   = $urandom;
    check(busy === 1'b1 && grp_ready === 1'b0, "R2", "busy after accept",
          {30'd0, busy, grp_ready}, 32'd2);
    k = 0;
    while (done !== 1'b1 && k < 20) begin
      @(posedge clk);
      @(negedge clk);
      k++;
    end
    check(k == n + 1, (n == 1) ? "R4" : "R3", $sformatf("done latency (%s)", req),
          k, n + 1);
    check(busy === 1'b0, "R2", "busy low at done", {31'd0, busy}, 32'd0);
    for (int l = 0; l < LANES; l++)
      check(lane_rdata[l*DW +: DW] === exp_rd[l], "R7",
            $sformatf("lane %0d data (%s)", l, req), lane_rdata[l*DW +: DW], exp_rd[l]);
    @(posedge clk);
    @(negedge clk);
    check(done === 1'b0, "R3", "done one cycle", {31'd0, done}, 32'd0);
    for (int l = 0; l < LANES; l++)
      check(lane_rdata[l*DW +: DW] === exp_rd[l], "R7",
            $sformatf("lane %0d held (%s)", l, req), lane_rdata[l*DW +: DW], exp_rd[l]);
  endtask

  task automatic clear_group();
    g_en = '0;
    g_we = '0;
    for (int l = 0; l < LANES; l++) begin
      g_addr[l] = '0;
      g_wd[l]   = '0;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_ABCD));
    repeat (3) @(negedge clk);
    // R8 reset state
    check(busy === 1'b0 && done === 1'b0 && grp_ready === 1'b1, "R8", "reset flags",
          {29'd0, busy, done, grp_ready}, 32'd1);
    check(lane_rdata === '0, "R8", "reset rdata", lane_rdata[31:0], 32'd0);
    rst_n = 1'b1;

    // R1: fill every word with unit-stride groups (distinct banks)
    for (int g = 0; g < NWORDS / LANES; g++) begin
      g_en = '1;
      g_we = '1;
      for (int l = 0; l < LANES; l++) begin
        g_addr[l] = AW'(g * LANES + l);
        g_wd[l]   = mix(g * LANES + l);
      end
      run_group("R1 fill");
    end

    // R1, R4: distinct banks, varied rows (stride 17)
    g_en = '1; g_we = '0;
    for (int l = 0; l < LANES; l++) g_addr[l] = AW'(l * 17 + 3);
    run_group("R4 stride17 read");

    // R1, R3: all lanes in one bank (stride 16) -> 8 service cycles
    g_en = '1; g_we = '0;
    for (int l = 0; l < LANES; l++) g_addr[l] = AW'(l * 16 + 5);
    run_group("R3 single bank");

    // R3: empty group still takes one service cycle
    clear_group();
    run_group("R3 empty");

    // R1: two lanes 16 words apart share a bank, third elsewhere -> N=2
    clear_group();
    g_en = 8'b0000_0111;
    g_addr[0] = 12'd5; g_addr[1] = 12'd21; g_addr[2] = 12'd6;
    run_group("R1 bank split");

    // R5: read lane0, write lane1, read lane3 on the same word
    clear_group();
    g_en = 8'b0000_1011; g_we = 8'b0000_0010;
    g_addr[0] = 12'd100; g_addr[1] = 12'd100; g_addr[3] = 12'd100;
    g_wd[1] = 32'hCAFE_0001;
    run_group("R5 order");

    // R6: two writes to one word, then read it back
    clear_group();
    g_en = 8'b0100_0100; g_we = 8'b0100_0100;
    g_addr[2] = 12'd200; g_addr[6] = 12'd200;
    g_wd[2] = 32'h1111_1111; g_wd[6] = 32'h6666_6666;
    run_group("R6 double write");
    clear_group();
    g_en = 8'b0000_0001; g_addr[0] = 12'd200;
    run_group("R6 readback");

    // R9: disabled lanes with write flag set, then read their words
    clear_group();
    g_en = 8'b0000_0001; g_we = 8'b1111_1111;
    for (int l = 0; l < LANES; l++) begin
      g_addr[l] = AW'(300 + l);
      g_wd[l]   = 32'hDEAD_0000 + l;
    end
    run_group("R9 disabled write");
    clear_group();
    g_en = '1;
    for (int l = 0; l < LANES; l++) g_addr[l] = AW'(300 + l);
    run_group("R9 readback");

    // Random groups squeezed into a 64-word window for many conflicts
    for (int it = 0; it < 400; it++) begin
      g_en = LANES'($urandom);
      for (int l = 0; l < LANES; l++) begin
        g_we[l]   = ($urandom % 10) < 3;
        g_addr[l] = (it % 4 == 0) ? AW'($urandom) : AW'($urandom % 64);
        g_wd[l]   = $urandom;
      end
      run_group("R5 random");
    end

    summary();
    $finish;
  end
endmodule